// File: doc/BRIEF.md
# Modem Line Change Status Register

This block holds the modem-control status byte of a classic asynchronous serial port. It watches four active-low handshake lines coming from a modem or peripheral: clear-to-send, data-set-ready, ring, and carrier-detect. Each line passes through a synchronizer. The block then reports two things for each line: its present asserted state, and a sticky flag that records a change since software last read the byte.

Software reads the byte by pulsing a read strobe for one cycle. The value presented during that cycle is the value read. At the end of that cycle all four change flags clear, unless a new change lands in the same cycle. While any change flag is set and the interrupt enable is high, an interrupt request is raised. Three of the lines flag any transition. The ring line flags only the end of a ring, which is its return from low to high.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, `statusOut` is 8'h00 and `irqOut` is 0, provided all four lines are held high.
- R2: Bit 0 sets when the synchronized clear-to-send line changes level in either direction.
- R3: Bit 1 sets when the synchronized data-set-ready line changes level in either direction.
- R4: Bit 2 sets only when the synchronized ring line goes from 0 to 1. A 1-to-0 transition of that line leaves bit 2 unchanged.
- R5: Bit 3 sets when the synchronized carrier-detect line changes level in either direction.
- R6: A cycle with `rdStrobe` high clears bits 3:0 at the end of that cycle.
- R7: A change detected in the same cycle as a read sets its flag, and the flag holds 1 after the read.
- R8: Bits 7:4 give the inverted synchronized levels: bit 4 for clear-to-send, bit 5 for data-set-ready, bit 6 for ring, and bit 7 for carrier-detect. A line change reaches these bits after two clock edges, and the matching flag sets at the third edge.
- R9: `irqOut` is 1 exactly when `irqEnable` is 1 and at least one of bits 3:0 is 1.
- R10: A change flag stays set until a read, whatever the lines do in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctsInN | input | 1 | Clear-to-send line, active low, asynchronous |
| dsrInN | input | 1 | Data-set-ready line, active low, asynchronous |
| ringInN | input | 1 | Ring line, active low, asynchronous |
| dcdInN | input | 1 | Carrier-detect line, active low, asynchronous |
| rdStrobe | input | 1 | One-cycle read of the status byte; clears change flags |
| irqEnable | input | 1 | Modem status interrupt enable |
| statusOut | output | 8 | Status byte: line states in 7:4, change flags in 3:0 |
| irqOut | output | 1 | Modem status interrupt request |

## Verification
Single-line toggles in each direction show whether a line's flag responds to both edges. They also show whether the ring line responds only to its rising edge. A toggle followed by idle cycles and further toggles without a read tests stickiness. A read issued exactly in the cycle where a change is being detected tells set-over-clear priority apart from clear-over-set. A long random run then mixes sparse toggles on all lines, reads, and enable changes. It is compared every cycle against a bench model, which exposes latency slips and swapped bit positions.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES = 4;

  // Control-to-datapath strobes
  typedef struct packed {
    logic [LINES-1:0] setFlag;   // per-line change detected this cycle
    logic             clearAll;  // register read this cycle
  } msrStrobe_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RESET_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl #(
  parameter int LINES = msr_pkg::LINES,
  parameter logic [LINES-1:0] RISE_ONLY = 4'b0100  // ring flags its trailing edge only (R4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   lineLvl,
  input  logic               rdStrobe,
  output msr_pkg::msrStrobe_t strobe
);
  logic [LINES-1:0] prevLvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLvl <= '1;
    else        prevLvl <= lineLvl;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (RISE_ONLY[i]) begin : g_rise
      assign strobe.setFlag[i] = ~prevLvl[i] & lineLvl[i];
    end else begin : g_any
      assign strobe.setFlag[i] = prevLvl[i] ^ lineLvl[i];   // R2 R3 R5
    end
  end

  assign strobe.clearAll = rdStrobe;  // R6
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath #(
  parameter int LINES = msr_pkg::LINES,
  localparam int WIDTH = 2 * LINES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  msr_pkg::msrStrobe_t strobe,
  input  logic [LINES-1:0]    lineLvl,
  input  logic                irqEnable,
  output logic [WIDTH-1:0]    statusOut,
  output logic                irqOut
);
  logic [LINES-1:0] flags;
  logic [LINES-1:0] flagsNext;

  // Set wins over the read clear (R7); flags hold otherwise (R10)
  always_comb begin
    flagsNext = strobe.clearAll ? '0 : flags;
    flagsNext = flagsNext | strobe.setFlag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flagsNext;
  end

  assign statusOut = {~lineLvl, flags};      // R8
  assign irqOut    = irqEnable & (|flags);   // R9
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctsInN,
  input  logic       dsrInN,
  input  logic       ringInN,
  input  logic       dcdInN,
  input  logic       rdStrobe,
  input  logic       irqEnable,
  output logic [7:0] statusOut,
  output logic       irqOut
);
  localparam int LINES = msr_pkg::LINES;

  logic [LINES-1:0]    rawLines;
  logic [LINES-1:0]    syncLines;
  msr_pkg::msrStrobe_t ctrlStrobe;

  assign rawLines = {dcdInN, ringInN, dsrInN, ctsInN};

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(rawLines), .syncOut(syncLines)
  );

  msr_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lineLvl(syncLines),
    .rdStrobe(rdStrobe), .strobe(ctrlStrobe)
  );

  msr_datapath #(.LINES(LINES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(ctrlStrobe), .lineLvl(syncLines),
    .irqEnable(irqEnable), .statusOut(statusOut), .irqOut(irqOut)
  );
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic                clk,
  input logic                rst_n,
  input logic                rdStrobe,
  input logic                irqEnable,
  input logic [7:0]          statusOut,
  input logic                irqOut,
  input msr_pkg::msrStrobe_t strobeIn
);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && strobeIn.setFlag == '0) |=> statusOut[3:0] == 4'h0);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobeIn.setFlag) |=> ((statusOut[3:0] & $past(strobeIn.setFlag)) == $past(strobeIn.setFlag)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStrobe |=> ((statusOut[3:0] & $past(statusOut[3:0])) == $past(statusOut[3:0])));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (irqEnable && (|statusOut[3:0])));

  p_irq_raised_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irqEnable && (|statusOut[3:0])) |-> irqOut);

  p_ring_trailing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusOut[2]) |-> ($past(statusOut[6]) == 1'b0 && $past(statusOut[6], 2) == 1'b1));
endmodule

bind modem_status_reg msr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rdStrobe(rdStrobe), .irqEnable(irqEnable),
  .statusOut(statusOut), .irqOut(irqOut), .strobeIn(ctrlStrobe)
);

// File: tb/sim_modem_status_reg.sv
`timescale 1ns/1ps
module sim_modem_status_reg;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] lines = 4'hF;   // {dcd, ring, dsr, cts}
  logic rdStrobe = 0;
  logic irqEnable = 0;
  logic [7:0] statusOut;
  logic irqOut;

  int errors = 0;
  int checks = 0;

  // model state
  logic [3:0] mS1 = 4'hF, mS2 = 4'hF, mPrev = 4'hF, mFlags = 4'h0;

  always #2.5 clk = ~clk;

  modem_status_reg u0 (
    .clk(clk), .rst_n(rst_n),
    .ctsInN(lines[0]), .dsrInN(lines[1]), .ringInN(lines[2]), .dcdInN(lines[3]),
    .rdStrobe(rdStrobe), .irqEnable(irqEnable),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  function automatic logic [3:0] edgeSet(logic [3:0] prev, logic [3:0] cur);
    logic [3:0] s;
    s = prev ^ cur;
    s[2] = ~prev[2] & cur[2];  // ring: rising only
    return s;
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    check(tag, {irqOut, statusOut}, {irqEnable & (|mFlags), ~mS2, mFlags});
  endtask

  // drive at negedge, clock once, advance model, compare at next negedge
  task automatic step(logic [3:0] l, logic rd, logic en, string tag);
    lines = l; rdStrobe = rd; irqEnable = en;
    @(posedge clk);
    mFlags = (rd ? 4'h0 : mFlags) | edgeSet(mPrev, mS2);
    mPrev = mS2; mS2 = mS1; mS1 = l;
    @(negedge clk);
    checkModel(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [3:0] l;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", {irqOut, statusOut}, 9'h000);

    // R2: cts falls, flag after third edge, level after second
    step(4'hE, 0, 1, "R2");
    step(4'hE, 0, 1, "R8");
    check("R8", {8'h0, statusOut[4]}, 9'h001);
    step(4'hE, 0, 1, "R2");
    check("R2", {8'h0, statusOut[0]}, 9'h001);
    check("R9", {8'h0, irqOut}, 9'h001);
    // R10: hold without read, cts back high
    repeat (4) step(4'hF, 0, 0, "R10");
    check("R10", {5'h0, statusOut[3:0]}, 9'h001);
    check("R9", {8'h0, irqOut}, 9'h000);
    // R6: read clears
    step(4'hF, 1, 0, "R6");
    step(4'hF, 0, 0, "R6");
    check("R6", {5'h0, statusOut[3:0]}, 9'h000);

    // R3 dsr, R5 dcd
    repeat (3) step(4'hD, 0, 0, "R3");
    check("R3", {8'h0, statusOut[1]}, 9'h001);
    step(4'hD, 1, 0, "R6");
    repeat (3) step(4'h5, 0, 0, "R5");
    check("R5", {8'h0, statusOut[3]}, 9'h001);
    check("R8", {5'h0, statusOut[7:4]}, 9'h00A);
    step(4'h5, 1, 0, "R6");

    // R4: ring falls -> no flag; rises -> flag
    repeat (4) step(4'h1, 0, 0, "R4");
    check("R4", {8'h0, statusOut[2]}, 9'h000);
    repeat (3) step(4'h5, 0, 0, "R4");
    check("R4", {8'h0, statusOut[2]}, 9'h001);
    step(4'h5, 1, 0, "R6");
    step(4'h5, 0, 0, "R6");

    // R7: read in the cycle where the cts change is detected
    step(4'h4, 0, 0, "R7");
    step(4'h4, 0, 0, "R7");
    step(4'h4, 1, 0, "R7");
    check("R7", {8'h0, statusOut[0]}, 9'h001);
    step(4'h4, 1, 1, "R7");
    step(4'h4, 0, 1, "R7");
    check("R7", {5'h0, statusOut[3:0]}, 9'h000);

    // random mix (R2 R3 R4 R5 R6 R8 R9 R10)
    l = 4'h4;
    for (int i = 0; i < 2000; i++) begin
      for (int b = 0; b < 4; b++)
        if (($urandom % 8) == 0) l[b] = ~l[b];
      step(l, ($urandom % 4) == 0, ($urandom % 2) == 0, "R8 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule